// File: doc/BRIEF.md
# Debug memory access command engine

This block carries out debug commands on a byte-wide synchronous memory bus. A framing stage upstream checks each command and then hands over a function code, a length and up to `PAYLOAD_MAX` payload bytes in parallel. The engine reads and writes target memory one bus operation per cycle. It then builds a reply made of a function code, a length and payload bytes, and holds that reply for a downstream transmitter.

The memory bus has four signals: an address, write data, a write strobe and read data. Read data for an address comes back in the cycle after that address is driven. Every memory write checks its result by reading the location back, with one exception: port output writes without a read-back, so that side-effecting devices are not read. The page byte in memory commands is accepted and then ignored. Register access and run control are recognised function codes, but this block answers them with an error reply.

Top module: `dbg_cmd_engine`

## Requirements
- R1: While reset is held, `busy_o`, `rsp_valid_o` and `mem_we_o` are all low.
- R2: A command is taken when `cmd_valid_i` is high and `busy_o` is low. `busy_o` then stays high until the reply is accepted (`rsp_valid_o` and `rsp_ready_i` both high), and it is low in the cycle after that. A command presented while busy is ignored.
- R3: Function 0xFF (status) replies with function 0xFF, length 3, and payload bytes `TARGET_ID`, `PAYLOAD_MAX` and 0.
- R4: Function 0xFE (read) takes payload bytes page, address low, address high and count, with count no greater than `PAYLOAD_MAX`. It replies with function 0xFE and length equal to the count. Payload byte i is the memory byte at address+i. A count of 0 gives an empty reply.
- R5: Function 0xFD (write) takes payload bytes page, address low, address high, followed by length−3 data bytes. The data is stored at consecutive addresses and then read back. When every byte matches, the reply is function 0xFD, length 1, status 0. A length of 3 writes nothing and replies with status 0.
- R6: If any byte read back after a 0xFD write differs from the data sent, the status is 1. Bytes written before the failing one remain stored.
- R7: Function 0xF9 (set bytes) takes length/4 records of four bytes each: page, address low, address high, new value. Any leftover bytes are ignored. For each record the engine reads the old byte, writes the new one and verifies it. The reply has function 0xF9, one old byte per record, and a length equal to the number of records.
- R8: When a 0xF9 record fails its verify, processing stops. The reply holds only the old bytes of the records before it, and no later record is written.
- R9: Function 0xF8 (port in) takes an address as low byte then high byte. It replies with function 0xF8, length 1, and the byte read from that address.
- R10: Function 0xF7 (port out) takes address low, address high and a data byte. It writes the byte and replies with function 0xF7, length 1, status 0, even if the location did not take the write.
- R11: Every other function code, including 0xFC, 0xFB and 0xFA, gives a reply with function 0xF0, length 1 and status 1.
- R12: The page byte has no effect. The same read with different page values returns the same data.
- R13: While `rsp_valid_o` is high and `rsp_ready_i` is low, the reply function, length and payload stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Validated command present |
| cmd_func_i | input | 8 | Command function code |
| cmd_len_i | input | 8 | Command payload length |
| cmd_data_i | input | PAYLOAD_MAX*8 | Command payload, byte i at bits 8i+7:8i |
| busy_o | output | 1 | Command in progress or reply pending |
| rsp_valid_o | output | 1 | Reply ready for the transmitter |
| rsp_ready_i | input | 1 | Transmitter accepts the reply |
| rsp_func_o | output | 8 | Reply function code |
| rsp_len_o | output | 8 | Reply payload length |
| rsp_data_o | output | PAYLOAD_MAX*8 | Reply payload, byte i at bits 8i+7:8i |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |

## Verification
The assertions assume that `rsp_ready_i` is the only input that ends a reply, and that commands arrive already framed. Under that assumption, a reply of function 0xF0, 0xFD or 0xF7 can only be a one-byte status of the value that function allows. Read counts and payload lengths are never checked against `PAYLOAD_MAX` inside the block. Every command the bench sends therefore stays within that limit, and a read-only region of the bench memory produces verify failures without needing any out-of-range request.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [7:0] FN_STAT  = 8'hFF;
  localparam logic [7:0] FN_READ  = 8'hFE;
  localparam logic [7:0] FN_WRITE = 8'hFD;
  localparam logic [7:0] FN_SET   = 8'hF9;
  localparam logic [7:0] FN_PIN   = 8'hF8;
  localparam logic [7:0] FN_POUT  = 8'hF7;
  localparam logic [7:0] FN_ERR   = 8'hF0;

  typedef enum logic [2:0] {
    OP_STAT, OP_READ, OP_WRITE, OP_SET, OP_PIN, OP_POUT, OP_BAD
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DESC, ST_RD_ISSUE, ST_RD_CAP, ST_WR, ST_VF_ISSUE, ST_VF_CAP,
    ST_PO, ST_SB_OLD, ST_SB_WR, ST_SB_VF, ST_SB_VFCAP, ST_REPLY
  } state_e;
endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
  import dbg_pkg::*;
(
  input  logic [7:0] func_i,
  output op_e        op_o
);
  always_comb begin
    unique case (func_i)
      FN_STAT:  op_o = OP_STAT;
      FN_READ:  op_o = OP_READ;
      FN_WRITE: op_o = OP_WRITE;
      FN_SET:   op_o = OP_SET;
      FN_PIN:   op_o = OP_PIN;
      FN_POUT:  op_o = OP_POUT;
      default:  op_o = OP_BAD; // register, run and unknown codes
    endcase
  end
endmodule

// File: rtl/dbg_reply_buf.sv
module dbg_reply_buf #(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [7:0]       wr_byte_i,
  output logic [DEPTH*8-1:0] data_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               data_o[8*i +: 8] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(i))    data_o[8*i +: 8] <= wr_byte_i;
    end
  end
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_pkg::*;
#(
  parameter int         PAYLOAD_MAX = 16,
  parameter logic [7:0] TARGET_ID   = 8'h5A,
  localparam int PW = PAYLOAD_MAX * 8,
  localparam int BW = (PAYLOAD_MAX > 1) ? $clog2(PAYLOAD_MAX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_func_i,
  input  logic [7:0]    cmd_len_i,
  input  logic [PW-1:0] cmd_data_i,
  output logic          busy_o,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [7:0]    rsp_func_o,
  output logic [7:0]    rsp_len_o,
  output logic [PW-1:0] rsp_data_o,
  output logic [15:0]   mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic          mem_we_o,
  input  logic [7:0]    mem_rdata_i
);
  state_e      state;
  op_e         dec_op;
  logic [7:0]  cmd_q [PAYLOAD_MAX];
  logic [15:0] base_q;
  logic [7:0]  idx_q, cnt_q, rfunc_q, rlen_q, old_q;

  logic          buf_we;
  logic [BW-1:0] buf_idx;
  logic [7:0]    buf_byte;

  dbg_op_decode u_dec (.func_i(cmd_func_i), .op_o(dec_op));

  dbg_reply_buf #(.DEPTH(PAYLOAD_MAX)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i(buf_we), .wr_idx_i(buf_idx), .wr_byte_i(buf_byte),
    .data_o(rsp_data_o)
  );

  function automatic logic [7:0] cbyte(input logic [9:0] pos);
    logic [7:0] r = '0;
    for (int i = 0; i < PAYLOAD_MAX; i++) if (pos == 10'(i)) r = cmd_q[i];
    return r;
  endfunction

  function automatic logic [7:0] din(input int k);
    return cmd_data_i[8*k +: 8];
  endfunction

  logic [9:0]  rec_pos;
  logic [15:0] rec_addr;
  logic [7:0]  rec_val, wr_val;
  logic        last, vf_bad;

  always_comb begin
    rec_pos  = {idx_q, 2'b00};
    rec_addr = {cbyte(rec_pos + 10'd2), cbyte(rec_pos + 10'd1)};
    rec_val  = cbyte(rec_pos + 10'd3);
    wr_val   = cbyte({2'b00, idx_q} + 10'd3);
    last     = (idx_q == cnt_q - 8'd1);
    vf_bad   = (mem_rdata_i != wr_val);
  end

  // bus and reply-buffer drive
  always_comb begin
    mem_addr_o  = base_q + {8'h00, idx_q};
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    buf_we      = 1'b0;
    buf_idx     = idx_q[BW-1:0];
    buf_byte    = '0;
    unique case (state)
      ST_IDLE: if (cmd_valid_i) begin
        if (dec_op == OP_BAD) begin
          buf_we = 1'b1; buf_idx = '0; buf_byte = 8'd1;
        end else if (dec_op == OP_WRITE && cmd_len_i <= 8'd3) begin
          buf_we = 1'b1; buf_idx = '0;
        end
      end
      ST_DESC: begin
        buf_we   = 1'b1;
        buf_byte = (idx_q == 8'd0) ? TARGET_ID :
                   (idx_q == 8'd1) ? 8'(PAYLOAD_MAX) : 8'h00;
      end
      ST_RD_CAP: begin buf_we = 1'b1; buf_byte = mem_rdata_i; end
      ST_WR: begin mem_we_o = 1'b1; mem_wdata_o = wr_val; end
      ST_VF_CAP: if (vf_bad || last) begin
        buf_we = 1'b1; buf_idx = '0; buf_byte = {7'd0, vf_bad};
      end
      ST_PO: begin
        mem_addr_o = base_q; mem_we_o = 1'b1; mem_wdata_o = cbyte(10'd2);
        buf_we = 1'b1; buf_idx = '0;
      end
      ST_SB_OLD, ST_SB_VF: mem_addr_o = rec_addr;
      ST_SB_WR: begin mem_addr_o = rec_addr; mem_we_o = 1'b1; mem_wdata_o = rec_val; end
      ST_SB_VFCAP: begin
        mem_addr_o = rec_addr;
        if (mem_rdata_i == rec_val) begin buf_we = 1'b1; buf_byte = old_q; end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      rfunc_q <= '0;
      rlen_q  <= '0;
      old_q   <= '0;
      for (int i = 0; i < PAYLOAD_MAX; i++) cmd_q[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmd_valid_i) begin
          for (int i = 0; i < PAYLOAD_MAX; i++) cmd_q[i] <= din(i);
          rfunc_q <= cmd_func_i;
          idx_q   <= '0;
          unique case (dec_op)
            OP_STAT: begin rlen_q <= 8'd3; state <= ST_DESC; end
            OP_READ: begin
              base_q <= {din(2), din(1)};
              cnt_q  <= din(3);
              rlen_q <= din(3);
              state  <= (din(3) == 8'd0) ? ST_REPLY : ST_RD_ISSUE;
            end
            OP_PIN: begin
              base_q <= {din(1), din(0)};
              cnt_q  <= 8'd1;
              rlen_q <= 8'd1;
              state  <= ST_RD_ISSUE;
            end
            OP_WRITE: begin
              base_q <= {din(2), din(1)};
              cnt_q  <= (cmd_len_i > 8'd3) ? cmd_len_i - 8'd3 : 8'd0;
              rlen_q <= 8'd1;
              state  <= (cmd_len_i > 8'd3) ? ST_WR : ST_REPLY;
            end
            OP_POUT: begin
              base_q <= {din(1), din(0)};
              rlen_q <= 8'd1;
              state  <= ST_PO;
            end
            OP_SET: begin
              cnt_q  <= {2'b00, cmd_len_i[7:2]};
              rlen_q <= 8'd0;
              state  <= (cmd_len_i[7:2] == 6'd0) ? ST_REPLY : ST_SB_OLD;
            end
            default: begin
              rfunc_q <= FN_ERR;
              rlen_q  <= 8'd1;
              state   <= ST_REPLY;
            end
          endcase
        end
        ST_DESC: begin
          idx_q <= idx_q + 8'd1;
          if (idx_q == 8'd2) state <= ST_REPLY;
        end
        ST_RD_ISSUE: state <= ST_RD_CAP;
        ST_RD_CAP: begin
          idx_q <= idx_q + 8'd1;
          state <= last ? ST_REPLY : ST_RD_ISSUE;
        end
        ST_WR: begin
          if (last) begin idx_q <= '0; state <= ST_VF_ISSUE; end
          else idx_q <= idx_q + 8'd1;
        end
        ST_VF_ISSUE: state <= ST_VF_CAP;
        ST_VF_CAP: begin
          if (vf_bad || last) state <= ST_REPLY;
          else begin idx_q <= idx_q + 8'd1; state <= ST_VF_ISSUE; end
        end
        ST_PO: state <= ST_REPLY;
        ST_SB_OLD: state <= ST_SB_WR;
        ST_SB_WR: begin old_q <= mem_rdata_i; state <= ST_SB_VF; end
        ST_SB_VF: state <= ST_SB_VFCAP;
        ST_SB_VFCAP: begin
          if (mem_rdata_i == rec_val) begin
            rlen_q <= idx_q + 8'd1;
            if (last) state <= ST_REPLY;
            else begin idx_q <= idx_q + 8'd1; state <= ST_SB_OLD; end
          end else state <= ST_REPLY; // truncate at first failed record
        end
        ST_REPLY: if (rsp_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign rsp_valid_o = (state == ST_REPLY);
  assign rsp_func_o  = rfunc_q;
  assign rsp_len_o   = rlen_q;
endmodule

// File: rtl/dbg_cmd_engine_chk.sv
module dbg_cmd_engine_chk #(
  parameter int PAYLOAD_MAX = 16,
  localparam int PW = PAYLOAD_MAX * 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic          busy_o,
  input logic          rsp_valid_o,
  input logic          rsp_ready_i,
  input logic [7:0]    rsp_func_o,
  input logic [7:0]    rsp_len_o,
  input logic [PW-1:0] rsp_data_o,
  input logic          mem_we_o
);
  a_r2_take_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o) |=> busy_o);
  a_r2_reply_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy_o);
  a_r2_handoff_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> !busy_o);
  a_r2_write_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  a_r13_reply_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_func_o) && $stable(rsp_len_o) && $stable(rsp_data_o)));
  a_r11_error_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_func_o == 8'hF0) |-> (rsp_len_o == 8'd1 && rsp_data_o[7:0] == 8'd1));
  a_r5_write_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_func_o == 8'hFD) |-> (rsp_len_o == 8'd1 && rsp_data_o[7:1] == 7'd0));
  a_r10_out_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_func_o == 8'hF7) |-> (rsp_len_o == 8'd1 && rsp_data_o[7:0] == 8'd0));
  a_r3_status_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_func_o == 8'hFF) |-> rsp_len_o == 8'd3);
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.PAYLOAD_MAX(PAYLOAD_MAX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .busy_o(busy_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_func_o(rsp_func_o),
  .rsp_len_o(rsp_len_o), .rsp_data_o(rsp_data_o), .mem_we_o(mem_we_o)
);

// File: tb/dbg_cmd_engine_test.sv
module dbg_cmd_engine_test;
  localparam int PM = 16;
  localparam int PW = PM * 8;
  localparam logic [7:0] TID = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [7:0] cmd_func = '0, cmd_len = '0;
  logic [PW-1:0] cmd_data = '0;
  logic busy, rsp_valid, mem_we;
  logic [7:0] rsp_func, rsp_len, mem_wdata, mem_rdata;
  logic [PW-1:0] rsp_data;
  logic [15:0] mem_addr;

  always #5 clk = ~clk;

  dbg_cmd_engine #(.PAYLOAD_MAX(PM), .TARGET_ID(TID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_func_i(cmd_func),
    .cmd_len_i(cmd_len), .cmd_data_i(cmd_data), .busy_o(busy), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_func_o(rsp_func), .rsp_len_o(rsp_len),
    .rsp_data_o(rsp_data), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a % 1024) * 7 + 3);
  endfunction

  // memory: 1 KiB aliased, addresses with bit 15 set are read-only
  logic [7:0] mem [1024];
  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  always @(posedge clk) begin
    if (mem_we && !mem_addr[15]) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
  end

  typedef struct packed {
    logic [7:0] func, len, d0, d1, d2, d3, efunc, elen, eb0;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'hFF, 8'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'd3, TID},        // R3
    '{8'hF8, 8'd2, 8'h10, 8'h00, 8'h00, 8'h00, 8'hF8, 8'd1, pat('h10)},  // R9
    '{8'hFC, 8'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'd1, 8'd1},       // R11
    '{8'hFB, 8'd2, 8'h01, 8'h02, 8'h00, 8'h00, 8'hF0, 8'd1, 8'd1},       // R11
    '{8'hFA, 8'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'd1, 8'd1},       // R11
    '{8'h12, 8'd1, 8'h33, 8'h00, 8'h00, 8'h00, 8'hF0, 8'd1, 8'd1},       // R11
    '{8'hF7, 8'd3, 8'h20, 8'h80, 8'h77, 8'h00, 8'hF7, 8'd1, 8'd0},       // R10 read-only target
    '{8'hFD, 8'd4, 8'h00, 8'h30, 8'h00, 8'hC4, 8'hFD, 8'd1, 8'd0},       // R5
    '{8'hF8, 8'd2, 8'h30, 8'h00, 8'h00, 8'h00, 8'hF8, 8'd1, 8'hC4},      // R5 stored
    '{8'hFD, 8'd4, 8'h00, 8'h40, 8'h80, 8'h11, 8'hFD, 8'd1, 8'd1},       // R6
    '{8'hFE, 8'd4, 8'h05, 8'h31, 8'h00, 8'h01, 8'hFE, 8'd1, pat('h31)},  // R4
    '{8'hF7, 8'd3, 8'h50, 8'h00, 8'h9D, 8'h00, 8'hF7, 8'd1, 8'd0},       // R10
    '{8'hF8, 8'd2, 8'h50, 8'h00, 8'h00, 8'h00, 8'hF8, 8'd1, 8'h9D},      // R10 stored
    '{8'hF8, 8'd2, 8'h20, 8'h80, 8'h00, 8'h00, 8'hF8, 8'd1, pat('h20)},  // R10 unchanged
    '{8'hFD, 8'd3, 8'h00, 8'h60, 8'h00, 8'h00, 8'hFD, 8'd1, 8'd0},       // R5 empty write
    '{8'hF9, 8'd3, 8'h00, 8'h70, 8'h00, 8'h00, 8'hF9, 8'd0, 8'd0}        // R7 no record
  };

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] r_func, r_len;
  logic [PW-1:0] r_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pk4(input logic [7:0] a, b, c, d);
    logic [PW-1:0] p = '0;
    p[31:0] = {d, c, b, a};
    return p;
  endfunction

  task automatic send(input logic [7:0] f, l, input logic [PW-1:0] pl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = f; cmd_len = l; cmd_data = pl;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take();
    while (!rsp_valid) @(negedge clk);
    r_func = rsp_func; r_len = rsp_len; r_data = rsp_data;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic run(input logic [7:0] f, l, input logic [PW-1:0] pl);
    send(f, l, pl);
    take();
  endtask

  task automatic peek(input logic [15:0] a, output logic [7:0] v);
    run(8'hF8, 8'd2, pk4(a[7:0], a[15:8], 8'h00, 8'h00));
    v = r_data[7:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 0);
    chk("R1 rsp_valid in reset", {31'd0, rsp_valid}, 0);
    chk("R1 mem_we in reset", {31'd0, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run(VECS[k].func, VECS[k].len, pk4(VECS[k].d0, VECS[k].d1, VECS[k].d2, VECS[k].d3));
      chk($sformatf("vec %0d func", k), {24'd0, r_func}, {24'd0, VECS[k].efunc});
      chk($sformatf("vec %0d len", k), {24'd0, r_len}, {24'd0, VECS[k].elen});
      if (VECS[k].elen != 0)
        chk($sformatf("vec %0d byte0", k), {24'd0, r_data[7:0]}, {24'd0, VECS[k].eb0});
    end

    // R3 remaining descriptor bytes
    run(8'hFF, 8'd0, '0);
    chk("R3 byte1", {24'd0, r_data[15:8]}, PM);
    chk("R3 byte2", {24'd0, r_data[23:16]}, 0);

    // R4 multi-byte read and empty read
    run(8'hFE, 8'd4, pk4(8'h00, 8'h00, 8'h01, 8'd5));
    chk("R4 len", {24'd0, r_len}, 5);
    for (int i = 0; i < 5; i++)
      chk($sformatf("R4 byte %0d", i), {24'd0, r_data[8*i +: 8]}, {24'd0, pat('h100 + i)});
    run(8'hFE, 8'd4, pk4(8'h00, 8'h00, 8'h01, 8'd0));
    chk("R4 empty len", {24'd0, r_len}, 0);

    // R12 page ignored
    run(8'hFE, 8'd4, pk4(8'hAB, 8'h00, 8'h01, 8'd3));
    for (int i = 0; i < 3; i++)
      chk($sformatf("R12 byte %0d", i), {24'd0, r_data[8*i +: 8]}, {24'd0, pat('h100 + i)});

    // R5 four-byte write
    run(8'hFD, 8'd7, pk4(8'h00, 8'h00, 8'h02, 8'hA1) | (pk4(8'hA2, 8'hA3, 8'hA4, 8'h00) << 32));
    chk("R5 status", {24'd0, r_data[7:0]}, 0);
    run(8'hFE, 8'd4, pk4(8'h00, 8'h00, 8'h02, 8'd4));
    chk("R5 readback", r_data[31:0], 32'hA4A3A2A1);

    // R6 failure part way, earlier bytes kept
    run(8'hFD, 8'd7, pk4(8'h00, 8'hFE, 8'h7F, 8'hB1) | (pk4(8'hB2, 8'hB3, 8'hB4, 8'h00) << 32));
    chk("R6 status", {24'd0, r_data[7:0]}, 1);
    peek(16'h7FFE, v); chk("R6 kept byte0", {24'd0, v}, 32'hB1);
    peek(16'h7FFF, v); chk("R6 kept byte1", {24'd0, v}, 32'hB2);

    // R7 three records, mixed pages
    run(8'hF9, 8'd12, pk4(8'h00, 8'h00, 8'h03, 8'h11) | (pk4(8'h00, 8'h05, 8'h03, 8'h22) << 32)
                    | (pk4(8'h09, 8'h10, 8'h03, 8'h33) << 64));
    chk("R7 len", {24'd0, r_len}, 3);
    chk("R7 old bytes", {8'd0, r_data[23:0]}, {8'd0, pat('h310), pat('h305), pat('h300)});
    peek(16'h0305, v); chk("R7 new value", {24'd0, v}, 32'h22);

    // R7 leftover bytes beyond whole records
    run(8'hF9, 8'd9, pk4(8'h00, 8'h20, 8'h03, 8'h44) | (pk4(8'h00, 8'h21, 8'h03, 8'h45) << 32)
                   | (pk4(8'h00, 8'h00, 8'h00, 8'h00) << 64));
    chk("R7 truncated len", {24'd0, r_len}, 2);
    peek(16'h0321, v); chk("R7 second record", {24'd0, v}, 32'h45);

    // R8 stop at failing record
    run(8'hF9, 8'd12, pk4(8'h00, 8'h30, 8'h03, 8'h5A) | (pk4(8'h00, 8'h23, 8'h81, 8'h55) << 32)
                    | (pk4(8'h00, 8'h40, 8'h01, 8'h66) << 64));
    chk("R8 len", {24'd0, r_len}, 1);
    chk("R8 old byte", {24'd0, r_data[7:0]}, {24'd0, pat('h330)});
    peek(16'h0140, v); chk("R8 later record untouched", {24'd0, v}, {24'd0, pat('h140)});
    peek(16'h0330, v); chk("R8 first record stored", {24'd0, v}, 32'h5A);

    // R13 and R2: stalled reply, command while busy ignored
    send(8'hFE, 8'd4, pk4(8'h00, 8'h08, 8'h01, 8'd2));
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_data;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_func = 8'hF7; cmd_len = 8'd3; cmd_data = pk4(8'h60, 8'h00, 8'hEE, 8'h00);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    chk("R13 valid held", {31'd0, rsp_valid}, 1);
    chk("R13 data held", {16'd0, rsp_data[15:0]}, {16'd0, r_data[15:0]});
    chk("R2 busy while pending", {31'd0, busy}, 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R2 idle after handoff", {31'd0, busy}, 0);
    peek(16'h0060, v); chk("R2 busy command ignored", {24'd0, v}, {24'd0, pat('h60)});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule